// File: doc/BRIEF.md
# Legacy Keyboard Port Trap Register

This block watches host I/O cycles aimed at the legacy keyboard controller, meaning the data port at 60h and the command port at 64h. It records each kind of access in a sticky status flag and raises a system management interrupt (SMI) request when an enabled flag is set. It also records an end-of-pass-through event. For every USB host controller function it gates that function's raw interrupt onto a PCI interrupt line, and it can route the same raw interrupt to the SMI request.

Several host controller functions share one copy of the status flags. Each function has its own 16-bit view of the register for reads and writes. The enable bits are held per function. The SMI logic ORs each enable across all functions before it combines the enable with its flag. A write of 1 to a flag from any function clears the single shared flag. The block has no state machine. Its state is the set of sticky flags plus the per-function enable registers.

Top module: `kbd_trap_csr`

## Requirements
- R1: After reset, every function reads 16'h2000, and both `smi_req` and `pci_irq` are low.
- R2: The status bit sets on the clock edge where the access is sampled. A read of port 60h sets bit 8, a write of 60h sets bit 9, a read of 64h sets bit 10 and a write of 64h sets bit 11. Any other address sets nothing. All functions read back the same status bits.
- R3: A write to port 64h with `a20_pass` high does not set bit 11. `a20_pass` has no effect on any other access.
- R4: `eop_evt` sets status bit 15 on the sampling edge.
- R5: Status bits 15 and 11:8 set on their event whatever the state of any enable bit.
- R6: A `cfg_wr` to any valid function with a 1 in bit 15 or in bits 11:8 clears that shared status bit. A 0 in those bits leaves it unchanged. If an event and a clear hit the same bit in the same cycle, the bit ends up set. A write with `cfg_func` at N_FUNC or above changes nothing.
- R7: Bit 12 reads the raw `usb_irq` of the selected function, whatever the value of bit 13. Writes to bit 12 have no effect.
- R8: Bits 13, 7, 4 and 3:0 are read/write per function, and only a `cfg_wr` addressed to that function changes them. Bits 3:0 enable the trap flags for bits 8, 9, 10 and 11 in that order. Bit 7 enables the bit 15 flag. Bit 4 enables the SMI from the USB interrupt. Bit 13 gates the PCI interrupt.
- R9: Bits 14, 6 and 5 always read 0 and ignore writes.
- R10: `smi_req` is high whenever a status flag is set and its enable bit is set in at least one function. It is also high when a function has `usb_irq` high together with its own bit 4.
- R11: `pci_irq[f]` is high exactly when `usb_irq[f]` is high and bit 13 of function f is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_rd | input | 1 | Host I/O read strobe, one cycle per access |
| io_wr | input | 1 | Host I/O write strobe, one cycle per access |
| io_addr | input | ADDR_W | I/O port address of the access |
| a20_pass | input | 1 | Marks a 64h write as an exempt gate pass-through access |
| eop_evt | input | 1 | End-of-pass-through event pulse |
| usb_irq | input | N_FUNC | Raw interrupt of each host controller function |
| cfg_wr | input | 1 | Register write strobe |
| cfg_func | input | FSEL_W | Function targeted by the write |
| cfg_wdata | input | 16 | Register write data |
| cfg_rsel | input | FSEL_W | Function whose view drives `cfg_rdata` |
| cfg_rdata | output | 16 | Combinational readback of the selected function |
| smi_req | output | 1 | System management interrupt request |
| pci_irq | output | N_FUNC | Gated interrupt per function |

## Verification
The hardest case to reach from the ports is a status flag that receives its setting event and a write-1 clear in the same cycle. The event must win, and the clear may come from a function other than the one the SMI enable lives in. A pseudo-random phase drives port accesses, pass-through flags, clears to every function (including one out of range) and interrupt patterns together for many cycles, so this collision and the cross-function enable ORing occur many times. A directed step then forces the collision once more. After every step, a bench model computes each function's full readback word, the SMI request and the PCI interrupt lines, and the bench compares all of them.

// File: rtl/kbd_trap_pkg.sv
package kbd_trap_pkg;

    localparam int REG_W    = 16;
    localparam int NUM_TRAP = 5;    // 0:data rd 1:data wr 2:cmd rd 3:cmd wr 4:end of pass-through

    localparam int USB_STS_BIT  = 12;
    localparam int USB_SMI_BIT  = 4;
    localparam int PIRQ_EN_BIT  = 13;

    typedef logic [NUM_TRAP-1:0] trap_vec_t;

    // register position of a trap status flag
    function automatic int sts_pos(input int t);
        return (t == NUM_TRAP-1) ? 15 : 8 + t;
    endfunction

    // register position of a trap enable bit
    function automatic int en_pos(input int t);
        return (t == NUM_TRAP-1) ? 7 : t;
    endfunction

endpackage

// File: rtl/kbd_trap_decode.sv
module kbd_trap_decode
    import kbd_trap_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] DATA_PORT = ADDR_W'(16'h0060),
    parameter logic [ADDR_W-1:0] CMD_PORT  = ADDR_W'(16'h0064)
) (
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              a20_pass,
    input  logic              eop_evt,
    output trap_vec_t         set_o
);

    logic hit_data;
    logic hit_cmd;

    always_comb begin
        hit_data = (io_addr == DATA_PORT);
        hit_cmd  = (io_addr == CMD_PORT);
        set_o    = '0;
        set_o[0] = io_rd & hit_data;
        set_o[1] = io_wr & hit_data;
        set_o[2] = io_rd & hit_cmd;
        set_o[3] = io_wr & hit_cmd & ~a20_pass;
        set_o[NUM_TRAP-1] = eop_evt;
    end

endmodule

// File: rtl/kbd_trap_flags.sv
module kbd_trap_flags
    import kbd_trap_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  trap_vec_t set_i,
    input  trap_vec_t clr_i,
    output trap_vec_t flags_o
);

    trap_vec_t flags_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= (flags_q & ~clr_i) | set_i;
        end
    end

    assign flags_o = flags_q;

    for (genvar t = 0; t < NUM_TRAP; t++) begin : g_chk
        // R5
        flag_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[t] |=> flags_q[t]);
        // R6
        flag_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[t] && !set_i[t]) |=> !flags_q[t]);
        // R6
        flag_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_i[t] && !set_i[t]) |=> $stable(flags_q[t]));
    end

endmodule

// File: rtl/kbd_trap_fn_regs.sv
module kbd_trap_fn_regs
    import kbd_trap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [REG_W-1:0] wdata_i,
    output trap_vec_t        trap_en_o,
    output logic             usb_smi_en_o,
    output logic             pirq_en_o
);

    trap_vec_t en_q;
    trap_vec_t en_d;
    logic      usb_en_q;
    logic      pirq_q;

    always_comb begin
        en_d = en_q;
        if (we_i) begin
            for (int t = 0; t < NUM_TRAP; t++) begin
                en_d[t] = wdata_i[en_pos(t)];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= '0;
            usb_en_q <= 1'b0;
            pirq_q   <= 1'b1;
        end else begin
            en_q <= en_d;
            if (we_i) begin
                usb_en_q <= wdata_i[USB_SMI_BIT];
                pirq_q   <= wdata_i[PIRQ_EN_BIT];
            end
        end
    end

    assign trap_en_o    = en_q;
    assign usb_smi_en_o = usb_en_q;
    assign pirq_en_o    = pirq_q;

    // R8
    pirq_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (pirq_q == $past(wdata_i[PIRQ_EN_BIT])));
    // R8
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> ($stable(en_q) && $stable(usb_en_q) && $stable(pirq_q)));

endmodule

// File: rtl/kbd_trap_csr.sv
module kbd_trap_csr
    import kbd_trap_pkg::*;
#(
    parameter int N_FUNC = 3,
    parameter int ADDR_W = 16,
    parameter int FSEL_W = (N_FUNC > 1) ? $clog2(N_FUNC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              a20_pass,
    input  logic              eop_evt,
    input  logic [N_FUNC-1:0] usb_irq,
    input  logic              cfg_wr,
    input  logic [FSEL_W-1:0] cfg_func,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic [FSEL_W-1:0] cfg_rsel,
    output logic [REG_W-1:0]  cfg_rdata,
    output logic              smi_req,
    output logic [N_FUNC-1:0] pci_irq
);

    localparam logic [ADDR_W-1:0] DATA_PORT = ADDR_W'(16'h0060);
    localparam logic [ADDR_W-1:0] CMD_PORT  = ADDR_W'(16'h0064);

    trap_vec_t         set_vec;
    trap_vec_t         clr_vec;
    trap_vec_t         flags;
    trap_vec_t         en_any;
    trap_vec_t         fn_en [N_FUNC];
    logic [N_FUNC-1:0] fn_usb_en;
    logic [N_FUNC-1:0] fn_pirq;
    logic              func_ok;

    kbd_trap_decode #(
        .ADDR_W    (ADDR_W),
        .DATA_PORT (DATA_PORT),
        .CMD_PORT  (CMD_PORT)
    ) decode_i (
        .io_rd    (io_rd),
        .io_wr    (io_wr),
        .io_addr  (io_addr),
        .a20_pass (a20_pass),
        .eop_evt  (eop_evt),
        .set_o    (set_vec)
    );

    assign func_ok = (int'(cfg_func) < N_FUNC);

    always_comb begin
        for (int t = 0; t < NUM_TRAP; t++) begin
            clr_vec[t] = cfg_wr & func_ok & cfg_wdata[sts_pos(t)];
        end
    end

    kbd_trap_flags flags_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_vec),
        .clr_i   (clr_vec),
        .flags_o (flags)
    );

    for (genvar f = 0; f < N_FUNC; f++) begin : g_fn
        kbd_trap_fn_regs regs_i (
            .clk          (clk),
            .rst_n        (rst_n),
            .we_i         (cfg_wr && (cfg_func == FSEL_W'(f))),
            .wdata_i      (cfg_wdata),
            .trap_en_o    (fn_en[f]),
            .usb_smi_en_o (fn_usb_en[f]),
            .pirq_en_o    (fn_pirq[f])
        );
    end

    always_comb begin
        en_any = '0;
        for (int f = 0; f < N_FUNC; f++) begin
            en_any = en_any | fn_en[f];
        end
    end

    assign smi_req = (|(flags & en_any)) | (|(usb_irq & fn_usb_en));
    assign pci_irq = usb_irq & fn_pirq;

    always_comb begin
        cfg_rdata = '0;
        for (int f = 0; f < N_FUNC; f++) begin
            if (cfg_rsel == FSEL_W'(f)) begin
                for (int t = 0; t < NUM_TRAP; t++) begin
                    cfg_rdata[sts_pos(t)] = flags[t];
                    cfg_rdata[en_pos(t)]  = fn_en[f][t];
                end
                cfg_rdata[USB_STS_BIT] = usb_irq[f];
                cfg_rdata[USB_SMI_BIT] = fn_usb_en[f];
                cfg_rdata[PIRQ_EN_BIT] = fn_pirq[f];
            end
        end
    end

    // R3
    a20_exempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && (io_addr == CMD_PORT) && a20_pass && !io_rd && !flags[3]) |=> !flags[3]);
    // R2
    data_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && (io_addr == DATA_PORT)) |=> flags[0]);
    // R10
    smi_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags == '0) && (usb_irq == '0)) |-> !smi_req);

endmodule

// File: tb/kbd_trap_csr_tb.sv
`timescale 1ns/1ps
module kbd_trap_csr_tb_top;

    localparam int NF = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          io_rd = 1'b0;
    logic          io_wr = 1'b0;
    logic [15:0]   io_addr = '0;
    logic          a20_pass = 1'b0;
    logic          eop_evt = 1'b0;
    logic [NF-1:0] usb_irq = '0;
    logic          cfg_wr = 1'b0;
    logic [1:0]    cfg_func = '0;
    logic [15:0]   cfg_wdata = '0;
    logic [1:0]    cfg_rsel = '0;
    logic [15:0]   cfg_rdata;
    logic          smi_req;
    logic [NF-1:0] pci_irq;

    int n_chk = 0;
    int n_bad = 0;

    logic [4:0] m_flags;
    logic [4:0] m_en [NF];
    logic [NF-1:0] m_usben;
    logic [NF-1:0] m_pirq;
    logic [31:0] rng = 32'h1badf00d;

    always #2.5 clk = ~clk;

    kbd_trap_csr #(.N_FUNC(NF)) dut_i (
        .clk(clk), .rst_n(rst_n), .io_rd(io_rd), .io_wr(io_wr), .io_addr(io_addr),
        .a20_pass(a20_pass), .eop_evt(eop_evt), .usb_irq(usb_irq), .cfg_wr(cfg_wr),
        .cfg_func(cfg_func), .cfg_wdata(cfg_wdata), .cfg_rsel(cfg_rsel),
        .cfg_rdata(cfg_rdata), .smi_req(smi_req), .pci_irq(pci_irq)
    );

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] exp_word(input int f);
        logic [15:0] w = '0;
        w[15]   = m_flags[4];
        w[11:8] = m_flags[3:0];
        w[13]   = m_pirq[f];
        w[12]   = usb_irq[f];
        w[7]    = m_en[f][4];
        w[4]    = m_usben[f];
        w[3:0]  = m_en[f][3:0];
        return w;
    endfunction

    task automatic check_all(input string ftag);
        logic [4:0] any_en = '0;
        logic       e_smi;
        for (int f = 0; f < NF; f++) any_en = any_en | m_en[f];
        e_smi = (|(m_flags & any_en)) | (|(usb_irq & m_usben));
        for (int f = 0; f < NF; f++) begin
            logic [15:0] e;
            cfg_rsel = 2'(f);
            #0.4;
            e = exp_word(f);
            chk({ftag, " status flags"}, cfg_rdata & 16'h8F00, e & 16'h8F00);
            chk("R7 raw usb bit", cfg_rdata & 16'h1000, e & 16'h1000);
            chk("R8 enables", cfg_rdata & 16'h209F, e & 16'h209F);
            chk("R9 reserved", cfg_rdata & 16'h4060, 16'h0000);
        end
        chk("R10 smi_req", {15'd0, smi_req}, {15'd0, e_smi});
        chk("R11 pci_irq", {13'd0, pci_irq}, {13'd0, usb_irq & m_pirq});
    endtask

    // drive at a falling edge, model the rising edge, return at the next falling edge
    task automatic step(input logic rd, input logic wr, input logic [15:0] addr,
                        input logic a20, input logic eop, input logic [NF-1:0] usb,
                        input logic cwr, input logic [1:0] cf, input logic [15:0] wd);
        logic [4:0] s;
        logic [4:0] c;
        io_rd = rd; io_wr = wr; io_addr = addr; a20_pass = a20; eop_evt = eop;
        usb_irq = usb; cfg_wr = cwr; cfg_func = cf; cfg_wdata = wd;
        s[0] = rd && addr == 16'h0060;
        s[1] = wr && addr == 16'h0060;
        s[2] = rd && addr == 16'h0064;
        s[3] = wr && addr == 16'h0064 && !a20;
        s[4] = eop;
        c = (cwr && cf < 2'(NF)) ? {wd[15], wd[11:8]} : 5'd0;
        @(posedge clk);
        m_flags = (m_flags & ~c) | s;
        if (cwr && cf < 2'(NF)) begin
            m_en[cf]    = {wd[7], wd[3:0]};
            m_usben[cf] = wd[4];
            m_pirq[cf]  = wd[13];
        end
        @(negedge clk);
        io_rd = 1'b0; io_wr = 1'b0; eop_evt = 1'b0; cfg_wr = 1'b0; a20_pass = 1'b0;
    endtask

    initial begin : watchdog
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [15:0] addrs [6];
        addrs = '{16'h0060, 16'h0064, 16'h0061, 16'h0065, 16'h0160, 16'h0063};
        m_flags = '0;
        for (int f = 0; f < NF; f++) m_en[f] = '0;
        m_usben = '0;
        m_pirq  = '1;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        for (int f = 0; f < NF; f++) begin
            cfg_rsel = 2'(f);
            #0.4;
            chk("R1 reset word", cfg_rdata, 16'h2000);
        end
        chk("R1 reset smi/pci", {12'd0, smi_req, pci_irq}, 16'd0);
        @(negedge clk);

        // decode sweep: every access kind against several addresses
        for (int ai = 0; ai < 6; ai++) begin
            for (int rw = 0; rw < 4; rw++) begin
                for (int a = 0; a < 2; a++) begin
                    for (int e = 0; e < 2; e++) begin
                        step(rw[0], rw[1], addrs[ai], a[0], e[0], '0, 1'b0, 2'd0, 16'h0);
                        check_all(e != 0 ? "R4" : (a != 0 ? "R3" : "R2"));
                        step(1'b0, 1'b0, 16'h0, 1'b0, 1'b0, '0, 1'b1, 2'(ai % NF), 16'h8F00);
                        check_all("R6");
                    end
                end
            end
        end

        // enable sweep: each function, each enable pattern, flags set under it
        for (int f = 0; f < NF; f++) begin
            for (int m = 0; m < 64; m++) begin
                logic [15:0] w;
                w = {2'b00, m[5], 5'd0, m[4], 2'b00, m[0], m[3:0]};
                step(1'b0, 1'b0, 16'h0, 1'b0, 1'b0, '0, 1'b1, 2'(f), w);
                check_all("R8");
                step(m[1], m[2], m[3] ? 16'h0064 : 16'h0060, 1'b0, m[0], 3'(m), 1'b0, 2'd0, 16'h0);
                check_all("R5");
                step(1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 3'(m), 1'b1, 2'(f), w | 16'h9F00);
                check_all("R6");
            end
        end

        // mixed pseudo-random traffic
        for (int i = 0; i < 1500; i++) begin
            logic [15:0] ad;
            rng = nxt(rng);
            case (rng[3:2])
                2'd0: ad = 16'h0060;
                2'd1: ad = 16'h0064;
                2'd2: ad = 16'h0062;
                default: ad = 16'h0064;
            endcase
            step(rng[0], rng[1], ad, rng[4], rng[9:5] == 5'd0, rng[12:10],
                 rng[14:13] == 2'd0, rng[16:15], rng[31:16]);
            check_all("R5");
        end

        // event and clear on the same flag in the same cycle
        step(1'b0, 1'b0, 16'h0, 1'b0, 1'b0, '0, 1'b1, 2'd1, 16'h8F00);
        step(1'b1, 1'b0, 16'h0060, 1'b0, 1'b0, '0, 1'b1, 2'd2, 16'h0100);
        check_all("R6");
        chk("R6 event beats clear", {15'd0, cfg_rdata[8]}, 16'd1);
        // zero write leaves flags, one to read-only and reserved bits ignored
        step(1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 3'b010, 1'b1, 2'd0, 16'h5060);
        check_all("R6");
        chk("R6 zero write holds flag", {15'd0, cfg_rdata[8]}, 16'd1);
        // out-of-range function writes nothing
        step(1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 3'b010, 1'b1, 2'd3, 16'hFFFF);
        check_all("R6");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule